// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending Logic

This block collects the interrupt sources of a two-channel serial controller into one shared pending register and drives a single level interrupt request to the processor. Each channel can raise three kinds of pending bit: transmit (a byte was written to its data location), receive (its receive buffer holds data) and external status (its receive buffer holds data while the controller is in DMA mode). Only channel A can read the shared register. The master enable and the receive and DMA mode selections come from channel A's control fields and apply to both channels. The transmit enable is set per channel.

The surrounding register file decodes the register pointer and supplies the enable fields, the receive-available flags and the access strobes. This block holds only the pending state and the request line. Software reads the pending register, or reads either data location, to acknowledge the interrupt. Pending bits are evaluated again on every clock. A source that is still active when the register is cleared therefore raises its bit again, so no event is lost.

Top module: `sio_irq_pend`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it goes high, `pend_rr` is 0, `irq` is 0 and `rd_err` is 0.
- R2: With `master_en` high, a cycle with `tx_wr[c]` and `tx_ie[c]` both high sets the transmit pending bit of channel c at the next clock edge. Channel A uses bit 4 and channel B uses bit 1. Index 0 of every two-bit port is channel A and index 1 is channel B. If `tx_ie[c]` is low, the strobe has no effect.
- R3: With `master_en` high, `dma_mode` low and `rx_mode` non-zero (bit 0 selects the first character, bit 1 selects all characters), a cycle with `rx_avail[c]` high sets the receive pending bit at the next edge. Channel A uses bit 5 and channel B uses bit 2.
- R4: With `master_en` and `dma_mode` high, `rx_avail[c]` sets the external-status pending bit instead of the receive bit. Channel A uses bit 3 and channel B uses bit 0.
- R5: While `master_en` is low, no pending bit is set and `irq` is 0.
- R6: A cycle with `pend_rd_a` high or any bit of `data_rd` high clears all pending bits at the next edge.
- R7: When a clear and a set condition occur in the same cycle, the bits being set are 1 after the edge.
- R8: A pending bit stays set after its source goes away, until a clear.
- R9: `irq` is high exactly when `master_en` is high and at least one of these holds: the channel-A transmit bit and `tx_ie[0]`; the channel-B transmit bit and `tx_ie[1]`; any receive bit with `rx_mode` non-zero; any external-status bit with `dma_mode`. `irq` follows the enables in the same cycle.
- R10: A cycle with `pend_rd_b` high makes `rd_err` high for exactly the next cycle and leaves the pending bits unchanged.
- R11: Bits 7 and 6 of `pend_rr` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Global interrupt enable (channel A control) |
| tx_ie | input | 2 | Per-channel transmit interrupt enable |
| rx_mode | input | 2 | Receive interrupt selection (first char / all chars) |
| dma_mode | input | 1 | DMA mode; receive data raises external-status bits |
| rx_avail | input | 2 | Per-channel receive buffer non-empty |
| tx_wr | input | 2 | Per-channel data-location write strobe |
| pend_rd_a | input | 1 | Pending register read through channel A |
| pend_rd_b | input | 1 | Pending register read attempted through channel B |
| data_rd | input | 2 | Per-channel data-location read strobe |
| pend_rr | output | 8 | Shared pending register |
| irq | output | 1 | Level interrupt request |
| rd_err | output | 1 | One-cycle flag for a channel-B pending read |

## Verification
The bench checks a clear that coincides with a still-present receive flag. A design where the clear wins would lose that event, and `pend_rr` would read 0 when the bit should be set. It checks DMA mode, where a design that also set the receive bit would show bits 5 or 2 alongside the external-status bits. It checks transmit strobes with a disabled enable or a low master enable, where a gating error shows up as a stray bit or a stray `irq`. It also checks a channel-B pending read, which must raise the error flag without touching the register. Random stimulus then compares the register and the request line against a behavioural model on every cycle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NCH  = 2;
  localparam int KINDS = 3;
  localparam int RR_W = 8;
  localparam int USED_W = NCH * KINDS;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_TX  = 2'd1,
    SRC_RX  = 2'd2
  } src_kind_e;

  // Channel A occupies the upper group of three bits, channel B the lower.
  function automatic int bit_pos(input int ch, input int kind);
    return ((ch == 0) ? KINDS : 0) + kind;
  endfunction
endpackage

// File: rtl/sio_irq_src.sv
module sio_irq_src
  import sio_irq_pkg::*;
(
  input  logic             master_en,
  input  logic             tx_ie,
  input  logic             tx_wr,
  input  logic             rx_avail,
  input  logic             rx_on,
  input  logic             dma_on,
  output logic [KINDS-1:0] set_v
);
  always_comb begin
    set_v = '0;
    if (master_en) begin
      set_v[int'(SRC_TX)] = tx_ie & tx_wr;
      if (dma_on) set_v[int'(SRC_EXT)] = rx_avail;
      else        set_v[int'(SRC_RX)]  = rx_on & rx_avail;
    end
  end
endmodule

// File: rtl/sio_irq_store.sv
module sio_irq_store
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [USED_W-1:0] set_vec,
  input  logic              clr,
  output logic [USED_W-1:0] pend_q
);
  logic [USED_W-1:0] pend_d;
  logic              pend_en;

  always_comb begin
    pend_en = clr | (|set_vec);
    pend_d  = (clr ? '0 : pend_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_vec == '0) |=> (pend_q == '0));
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/sio_irq_req.sv
module sio_irq_req
  import sio_irq_pkg::*;
(
  input  logic [USED_W-1:0] pend_q,
  input  logic              master_en,
  input  logic [NCH-1:0]    tx_ie,
  input  logic              rx_on,
  input  logic              dma_on,
  output logic              irq
);
  logic [NCH-1:0] tx_hit, rx_hit, ext_hit;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      tx_hit[c]  = pend_q[bit_pos(c, int'(SRC_TX))] & tx_ie[c];
      rx_hit[c]  = pend_q[bit_pos(c, int'(SRC_RX))] & rx_on;
      ext_hit[c] = pend_q[bit_pos(c, int'(SRC_EXT))] & dma_on;
    end
    irq = master_en & ((|tx_hit) | (|rx_hit) | (|ext_hit));
  end
endmodule

// File: rtl/sio_irq_pend.sv
module sio_irq_pend
  import sio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master_en,
  input  logic [NCH-1:0]  tx_ie,
  input  logic [1:0]      rx_mode,
  input  logic            dma_mode,
  input  logic [NCH-1:0]  rx_avail,
  input  logic [NCH-1:0]  tx_wr,
  input  logic            pend_rd_a,
  input  logic            pend_rd_b,
  input  logic [NCH-1:0]  data_rd,
  output logic [RR_W-1:0] pend_rr,
  output logic            irq,
  output logic            rd_err
);
  logic              rx_on;
  logic              clr;
  logic [KINDS-1:0]  set_ch [NCH];
  logic [USED_W-1:0] set_vec;
  logic [USED_W-1:0] pend_q;
  logic              err_d;

  assign rx_on = |rx_mode;
  assign clr   = pend_rd_a | (|data_rd);

  for (genvar c = 0; c < NCH; c++) begin : g_src
    sio_irq_src u_src (
      .master_en (master_en),
      .tx_ie     (tx_ie[c]),
      .tx_wr     (tx_wr[c]),
      .rx_avail  (rx_avail[c]),
      .rx_on     (rx_on),
      .dma_on    (dma_mode),
      .set_v     (set_ch[c])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < KINDS; k++)
        set_vec[bit_pos(c, k)] = set_ch[c][k];
  end

  sio_irq_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (clr),
    .pend_q  (pend_q)
  );

  sio_irq_req u_req (
    .pend_q    (pend_q),
    .master_en (master_en),
    .tx_ie     (tx_ie),
    .rx_on     (rx_on),
    .dma_on    (dma_mode),
    .irq       (irq)
  );

  assign pend_rr = {{(RR_W-USED_W){1'b0}}, pend_q};

  assign err_d = pend_rd_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_err <= 1'b0;
    else        rd_err <= err_d;
  end

  a_r5_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq);
  a_r9_no_pend_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rr == '0) |-> !irq);
  a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd_b |=> rd_err);
  a_r10_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd_b && !pend_rd_a && data_rd == '0 && set_vec == '0) |=> $stable(pend_rr));
endmodule

// File: tb/sio_irq_pend_bench.sv
`timescale 1ns/1ps
module sio_irq_pend_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       master_en;
  logic [1:0] tx_ie, rx_mode, rx_avail, tx_wr, data_rd;
  logic       dma_mode, pend_rd_a, pend_rd_b;
  logic [7:0] pend_rr;
  logic       irq, rd_err;

  integer n_chk = 0;
  integer n_bad = 0;
  bit     done = 0;
  string  phase = "R1";

  logic [7:0] m_pend;
  logic       m_err;

  always #4 clk = ~clk;

  sio_irq_pend u_sio_irq_pend (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .tx_ie(tx_ie),
    .rx_mode(rx_mode), .dma_mode(dma_mode), .rx_avail(rx_avail),
    .tx_wr(tx_wr), .pend_rd_a(pend_rd_a), .pend_rd_b(pend_rd_b),
    .data_rd(data_rd), .pend_rr(pend_rr), .irq(irq), .rd_err(rd_err)
  );

  // Behavioural reference: bit 5 rxA, 4 txA, 3 extA, 2 rxB, 1 txB, 0 extB
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 8'h00;
      m_err  <= 1'b0;
    end else begin
      logic [7:0] nx;
      nx = (pend_rd_a || data_rd != 2'b00) ? 8'h00 : m_pend;
      if (master_en) begin
        if (tx_wr[0] && tx_ie[0]) nx[4] = 1'b1;
        if (tx_wr[1] && tx_ie[1]) nx[1] = 1'b1;
        if (dma_mode) begin
          if (rx_avail[0]) nx[3] = 1'b1;
          if (rx_avail[1]) nx[0] = 1'b1;
        end else if (rx_mode != 2'b00) begin
          if (rx_avail[0]) nx[5] = 1'b1;
          if (rx_avail[1]) nx[2] = 1'b1;
        end
      end
      m_pend <= nx;
      m_err  <= pend_rd_b;
    end
  end

  function automatic logic model_irq();
    logic any;
    any = (m_pend[4] && tx_ie[0]) || (m_pend[1] && tx_ie[1]) ||
          ((rx_mode != 2'b00) && (m_pend[5] || m_pend[2])) ||
          (dma_mode && (m_pend[3] || m_pend[0]));
    return master_en && any;
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Wait one cycle, then compare every output against the model.
  task automatic step();
    @(negedge clk);
    #1;
    cmp(phase, pend_rr, m_pend, "pend_rr");
    cmp(phase, {7'd0, irq}, {7'd0, model_irq()}, "irq");
    cmp(phase, {7'd0, rd_err}, {7'd0, m_err}, "rd_err");
  endtask

  task automatic idle();
    tx_wr = 2'b00; data_rd = 2'b00; pend_rd_a = 1'b0; pend_rd_b = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; master_en = 1'b0; tx_ie = 2'b00; rx_mode = 2'b00;
    dma_mode = 1'b0; rx_avail = 2'b00; idle();
    repeat (3) @(negedge clk);
    #1;
    cmp("R1", pend_rr, 8'h00, "pend_rr in reset");
    cmp("R1", {7'd0, irq}, 8'h00, "irq in reset");
    rst_n = 1'b1;
    step();
    cmp("R1", pend_rr, 8'h00, "pend_rr after reset");

    phase = "R2";
    master_en = 1'b1; tx_ie = 2'b11; tx_wr = 2'b01; step();
    cmp("R2", pend_rr, 8'h10, "txA bit");
    tx_wr = 2'b10; step();
    cmp("R2", pend_rr, 8'h12, "txB bit");
    cmp("R9", {7'd0, irq}, 8'h01, "irq with tx pend");
    tx_wr = 2'b00; tx_ie = 2'b00; step();
    cmp("R9", {7'd0, irq}, 8'h00, "irq with tx_ie off");
    tx_wr = 2'b11; step();
    cmp("R8", pend_rr, 8'h12, "no set when tx_ie off, sticky");
    tx_wr = 2'b00; data_rd = 2'b01; step();
    cmp("R6", pend_rr, 8'h00, "data read clears");
    idle();

    phase = "R5";
    master_en = 1'b0; rx_mode = 2'b01; rx_avail = 2'b11; tx_ie = 2'b11; tx_wr = 2'b11;
    step(); step();
    cmp("R5", pend_rr, 8'h00, "no set without master");
    cmp("R5", {7'd0, irq}, 8'h00, "irq without master");
    tx_wr = 2'b00; rx_avail = 2'b00; step();

    phase = "R3";
    master_en = 1'b1; rx_avail = 2'b01; step();
    cmp("R3", pend_rr, 8'h20, "rxA bit");
    rx_avail = 2'b10; rx_mode = 2'b10; step();
    cmp("R3", pend_rr, 8'h24, "rxB bit");
    cmp("R9", {7'd0, irq}, 8'h01, "irq rx");

    phase = "R6";
    rx_avail = 2'b00; pend_rd_a = 1'b1; step();
    cmp("R6", pend_rr, 8'h00, "pending read clears");
    idle();

    phase = "R7";
    rx_avail = 2'b01; pend_rd_a = 1'b1; data_rd = 2'b10; step();
    cmp("R7", pend_rr, 8'h20, "set wins over clear");
    idle(); rx_avail = 2'b00; data_rd = 2'b01; step(); idle();

    phase = "R4";
    dma_mode = 1'b1; rx_avail = 2'b10; step();
    cmp("R4", pend_rr, 8'h01, "extB bit, no rx bit");
    rx_avail = 2'b01; step();
    cmp("R4", pend_rr, 8'h09, "extA bit");
    cmp("R9", {7'd0, irq}, 8'h01, "irq dma");

    phase = "R10";
    dma_mode = 1'b0; rx_avail = 2'b00; pend_rd_b = 1'b1; step();
    cmp("R10", {7'd0, rd_err}, 8'h01, "error flag");
    cmp("R10", pend_rr, 8'h09, "pending unchanged");
    pend_rd_b = 1'b0; step();
    cmp("R10", {7'd0, rd_err}, 8'h00, "error flag one cycle");

    phase = "R9";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      master_en = (r[2:0] != 3'd0);
      tx_ie     = r[4:3];
      rx_mode   = r[6:5];
      dma_mode  = (r[9:7] == 3'd0);
      rx_avail  = r[11:10] & {r[12], r[13]};
      tx_wr     = r[15:14];
      pend_rd_a = (r[19:16] == 4'd0);
      pend_rd_b = (r[23:20] == 4'd0);
      data_rd   = {r[27:24] == 4'd1, r[27:24] == 4'd2};
      step();
      cmp("R11", {6'd0, pend_rr[7:6]}, 8'h00, "upper bits");
    end
    idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule